// File: doc/BRIEF.md
# Lock Detector Integration Controller

This block runs the integrate-and-dump cycle behind a carrier lock detector. On every valid input sample it adds the magnitude of the in-phase and the quadrature value to two running accumulators. When a programmed number of samples has been taken in, both sums are copied into holding registers and the running accumulators start again from zero. A host reads the holding registers. To get values that cannot change while it reads them, it first stops the sequencer.

Two control modes are offered. In free-running mode, cycles follow each other without a pause until the host writes a halt command. The cycle in progress is always completed before the sequencer stops. In host mode, the sequencer stops by itself at the end of every cycle. In both modes a ready flag in the status byte shows that the sequencer has stopped, and a separate restart write lets it run again. Deciding lock from the sums, and anything that uses the lock decision, is left to surrounding logic.

Top module: `lock_integ_ctrl`

## Requirements
- R1: When a cycle of L valid samples ends, `hold_i` and `hold_q` equal the sums of |I| and |Q| over exactly those samples. The most negative input counts as 2^(DW-1). Clocks with `samp_valid` low add nothing, and the holding registers do not change before the last sample of the cycle.
- R2: In free-running mode (mode register bit 0 = 0), a new cycle starts right after each dump, the holding registers reload every L samples, and status bit 7 stays 0.
- R3: A write to address 24, with any data, requests a halt. The cycle in progress runs to its last sample, and status bit 7 goes to 1 on the same clock edge on which the holding registers load. Status bits 6..0 always read 0.
- R4: While stopped, input samples are ignored, `hold_i`/`hold_q` stay unchanged, the running accumulators stay at zero, and status bit 7 stays 1 until a restart write is made.
- R5: In host mode (a write to address 21 with data bit 0 = 1), the sequencer stops at the end of every cycle without any halt write.
- R6: A write to address 25, with any data, restarts a stopped sequencer. Status bit 7 is 0 after that edge. A sample presented in the same clock as the restart write is not counted, and the new cycle counts from the next valid sample.
- R7: A halt write made while the sequencer is stopped has no effect and is not held over. After the restart, the next cycle in free-running mode ends without stopping.
- R8: A restart write while the sequencer is running is ignored. The cycle count and the sums carry on undisturbed.
- R9: A write to address 20 sets the cycle length L from data bits 15..0. A value of 0 is treated as 1.
- R10: A synchronous reset clears the holding registers, the accumulators and the status byte. It also selects free-running mode, leaves the sequencer running, and sets L to the parameter DEF_LEN (8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_valid | input | 1 | Input sample qualifier |
| samp_i | input | DW | In-phase sample, two's complement |
| samp_q | input | DW | Quadrature sample, two's complement |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register write address |
| reg_wdata | input | 16 | Register write data |
| status | output | 8 | Status byte; bit 7 = stopped, sums ready |
| hold_i | output | DW+16 | Held in-phase magnitude sum |
| hold_q | output | DW+16 | Held quadrature magnitude sum |

## Verification
Every result is a registered output, so each one is due on the first rising edge after its stimulus. The holding registers and the ready flag change on the edge that takes in the last sample of a cycle. The ready flag clears on the edge that takes in the restart write. Configuration writes apply from the following clock. The bench applies each stimulus for one clock, waits for that edge, and compares the outputs one time unit later, before the next stimulus is applied. It also compares the outputs one sample before a cycle's end, to confirm that nothing changed early.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

    localparam int REG_AW   = 5;
    localparam int REG_DW   = 16;
    localparam int LEN_W    = 16;
    localparam int STAT_W   = 8;
    localparam int READY_BIT = 7;

    localparam logic [REG_AW-1:0] ADDR_LEN     = 5'd20;
    localparam logic [REG_AW-1:0] ADDR_MODE    = 5'd21;
    localparam logic [REG_AW-1:0] ADDR_HALT    = 5'd24;
    localparam logic [REG_AW-1:0] ADDR_RESTART = 5'd25;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_STOP = 1'b1
    } lkd_state_e;

    typedef struct packed {
        logic halt;
        logic restart;
    } lkd_cmd_t;

    function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] l);
        return (l == '0) ? LEN_W'(1) : l;
    endfunction

endpackage

// File: rtl/lkd_regif.sv
module lkd_regif
    import lkd_pkg::*;
#(
    parameter logic [LEN_W-1:0] DEF_LEN = 16'd8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output lkd_cmd_t          cmd,
    output logic [LEN_W-1:0]  len,
    output logic              host_mode
);

    always_comb begin
        cmd.halt    = reg_wr && (reg_addr == ADDR_HALT);
        cmd.restart = reg_wr && (reg_addr == ADDR_RESTART);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len       <= DEF_LEN;
            host_mode <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_LEN)
                len <= reg_wdata[LEN_W-1:0];
            if (reg_addr == ADDR_MODE)
                host_mode <= reg_wdata[0];
        end
    end

endmodule

// File: rtl/lkd_accum.sv
module lkd_accum
    import lkd_pkg::*;
#(
    parameter int DW    = 8,
    parameter int ACC_W = DW + LEN_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run_en,
    input  logic                 samp_valid,
    input  logic signed [DW-1:0] samp_i,
    input  logic signed [DW-1:0] samp_q,
    input  logic [LEN_W-1:0]     len,
    output logic                 dump,
    output logic                 acc_zero,
    output logic [ACC_W-1:0]     hold_i,
    output logic [ACC_W-1:0]     hold_q
);

    localparam int CMP_W = LEN_W + 1;

    logic [ACC_W-1:0] acc_i, acc_q;
    logic [LEN_W-1:0] cnt;
    logic [DW-1:0]    mag_i, mag_q;
    logic [ACC_W-1:0] sum_i, sum_q;
    logic             last;

    function automatic logic [DW-1:0] mag(input logic [DW-1:0] x);
        return x[DW-1] ? (~x + 1'b1) : x;
    endfunction

    always_comb begin
        mag_i    = mag(samp_i);
        mag_q    = mag(samp_q);
        sum_i    = acc_i + ACC_W'(mag_i);
        sum_q    = acc_q + ACC_W'(mag_q);
        last     = (CMP_W'(cnt) + CMP_W'(1)) >= CMP_W'(eff_len(len));
        dump     = run_en && samp_valid && last;
        acc_zero = (acc_i == '0) && (acc_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_i  <= '0;
            acc_q  <= '0;
            hold_i <= '0;
            hold_q <= '0;
            cnt    <= '0;
        end else if (run_en && samp_valid) begin
            if (last) begin
                hold_i <= sum_i;
                hold_q <= sum_q;
                acc_i  <= '0;
                acc_q  <= '0;
                cnt    <= '0;
            end else begin
                acc_i  <= sum_i;
                acc_q  <= sum_q;
                cnt    <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lkd_fsm.sv
module lkd_fsm
    import lkd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lkd_cmd_t cmd,
    input  logic     host_mode,
    input  logic     dump,
    output logic     run_en,
    output logic     stopped
);

    lkd_state_e state;
    logic       halt_pend;

    assign run_en  = (state == ST_RUN);
    assign stopped = (state == ST_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RUN;
            halt_pend <= 1'b0;
        end else begin
            case (state)
                ST_RUN: begin
                    if (dump && (host_mode || halt_pend || cmd.halt)) begin
                        state     <= ST_STOP;
                        halt_pend <= 1'b0;
                    end else if (cmd.halt) begin
                        halt_pend <= 1'b1;
                    end
                end
                ST_STOP: begin
                    halt_pend <= 1'b0;
                    if (cmd.restart)
                        state <= ST_RUN;
                end
                default: state <= ST_RUN;
            endcase
        end
    end

endmodule

// File: rtl/lock_integ_ctrl.sv
module lock_integ_ctrl
    import lkd_pkg::*;
#(
    parameter int               DW      = 8,
    parameter logic [LEN_W-1:0] DEF_LEN = 16'd8,
    localparam int              ACC_W   = DW + LEN_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 samp_valid,
    input  logic signed [DW-1:0] samp_i,
    input  logic signed [DW-1:0] samp_q,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [REG_DW-1:0]    reg_wdata,
    output logic [STAT_W-1:0]    status,
    output logic [ACC_W-1:0]     hold_i,
    output logic [ACC_W-1:0]     hold_q
);

    lkd_cmd_t         cmd_w;
    logic [LEN_W-1:0] len_w;
    logic             mode_w;
    logic             dump_w;
    logic             run_w;
    logic             stop_w;
    logic             acc_zero_w;

    lkd_regif #(.DEF_LEN(DEF_LEN)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cmd       (cmd_w),
        .len       (len_w),
        .host_mode (mode_w)
    );

    lkd_accum #(.DW(DW), .ACC_W(ACC_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_w),
        .samp_valid (samp_valid),
        .samp_i     (samp_i),
        .samp_q     (samp_q),
        .len        (len_w),
        .dump       (dump_w),
        .acc_zero   (acc_zero_w),
        .hold_i     (hold_i),
        .hold_q     (hold_q)
    );

    lkd_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd_w),
        .host_mode (mode_w),
        .dump      (dump_w),
        .run_en    (run_w),
        .stopped   (stop_w)
    );

    always_comb begin
        status            = '0;
        status[READY_BIT] = stop_w;
    end

endmodule

// File: rtl/lkd_checker.sv
module lkd_checker #(
    parameter int HW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          stopped,
    input logic          halt_wr,
    input logic          restart_wr,
    input logic          host_mode,
    input logic          dump,
    input logic          acc_zero,
    input logic [HW-1:0] hold_i,
    input logic [HW-1:0] hold_q
);

    assert_hold_only_at_dump_R1: assert property (@(posedge clk) disable iff (rst)
        !dump |=> ($stable(hold_i) && $stable(hold_q)));

    assert_stop_at_cycle_end_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(stopped) |-> $past(dump));

    assert_stay_stopped_R4: assert property (@(posedge clk) disable iff (rst)
        (stopped && !restart_wr) |=> stopped);

    assert_acc_clear_when_stopped_R4: assert property (@(posedge clk) disable iff (rst)
        stopped |-> acc_zero);

    assert_host_auto_stop_R5: assert property (@(posedge clk) disable iff (rst)
        (host_mode && dump) |=> stopped);

    assert_restart_runs_R6: assert property (@(posedge clk) disable iff (rst)
        (stopped && restart_wr) |=> !stopped);

    assert_no_dump_when_stopped_R4: assert property (@(posedge clk) disable iff (rst)
        stopped |-> !dump);

    assert_halt_while_stopped_R7: assert property (@(posedge clk) disable iff (rst)
        (stopped && halt_wr && !restart_wr) |=> stopped);

endmodule

bind lock_integ_ctrl lkd_checker #(.HW(ACC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stopped    (stop_w),
    .halt_wr    (cmd_w.halt),
    .restart_wr (cmd_w.restart),
    .host_mode  (mode_w),
    .dump       (dump_w),
    .acc_zero   (acc_zero_w),
    .hold_i     (hold_i),
    .hold_q     (hold_q)
);

// File: tb/sim_lock_integ_ctrl.sv
module sim_lock_integ_ctrl;

    localparam int CLK_T = 10;
    localparam int DW    = 8;
    localparam int HW    = DW + 16;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 samp_valid;
    logic signed [DW-1:0] samp_i, samp_q;
    logic                 reg_wr;
    logic [4:0]           reg_addr;
    logic [15:0]          reg_wdata;
    logic [7:0]           status;
    logic [HW-1:0]        hold_i, hold_q;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_i = 0;
    int exp_q = 0;
    bit done  = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    lock_integ_ctrl #(.DW(DW), .DEF_LEN(16'd8)) u0 (
        .clk(clk), .rst(rst), .samp_valid(samp_valid), .samp_i(samp_i),
        .samp_q(samp_q), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .status(status), .hold_i(hold_i), .hold_q(hold_q)
    );

    function automatic int absv(input int x);
        return (x < 0) ? -x : x;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input int iv, input int qv,
                        input logic w, input logic [4:0] a, input logic [15:0] d);
        samp_valid = v;
        samp_i     = iv[DW-1:0];
        samp_q     = qv[DW-1:0];
        reg_wr     = w;
        reg_addr   = a;
        reg_wdata  = d;
        @(posedge clk);
        #1;
        samp_valid = 1'b0;
        reg_wr     = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        step(1'b0, 0, 0, 1'b1, a, d);
    endtask

    // Feeds n valid samples with idle gaps; optionally adds them to the expected sums.
    task automatic feed(input int n, input int seed, input bit add);
        for (int k = 0; k < n; k++) begin
            int iv;
            int qv;
            iv = ((seed * 37 + k * 53) % 256) - 128;
            qv = ((seed * 91 + k * 29 + 5) % 256) - 128;
            if (k == 1) iv = -128;
            step(1'b1, iv, qv, 1'b0, 5'd0, 16'd0);
            if (add) begin
                exp_i += absv(iv);
                exp_q += absv(qv);
            end
            step(1'b0, 0, 0, 1'b0, 5'd0, 16'd0);
        end
    endtask

    task automatic clr_exp();
        exp_i = 0;
        exp_q = 0;
    endtask

    task automatic check_sums(input string req);
        check(req, "hold_i", int'(hold_i), exp_i);
        check(req, "hold_q", int'(hold_q), exp_q);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(1'b0, 0, 0, 1'b0, 5'd0, 16'd0);
        step(1'b0, 0, 0, 1'b0, 5'd0, 16'd0);
        rst = 1'b0;
        check("R10", "status after reset", int'(status), 0);
        check("R10", "hold_i after reset", int'(hold_i), 0);
        check("R10", "hold_q after reset", int'(hold_q), 0);
    endtask

    task automatic t_default_len();
        clr_exp();
        feed(7, 3, 1'b1);
        check("R10", "hold_i before 8th sample", int'(hold_i), 0);
        feed(1, 4, 1'b1);
        check_sums("R10");
        check("R10", "running after default cycle", int'(status), 0);
    endtask

    task automatic t_free_run();
        wr(5'd20, 16'd4);
        clr_exp();
        feed(4, 11, 1'b1);
        check_sums("R1");
        check("R2", "status first cycle", int'(status), 0);
        begin
            int pi;
            int pq;
            pi = exp_i;
            pq = exp_q;
            clr_exp();
            feed(3, 12, 1'b1);
            check("R1", "hold_i before cycle end", int'(hold_i), pi);
            check("R1", "hold_q before cycle end", int'(hold_q), pq);
        end
        feed(1, 13, 1'b1);
        check_sums("R2");
        check("R2", "status second cycle", int'(status), 0);
    endtask

    task automatic t_halt();
        clr_exp();
        feed(2, 21, 1'b1);
        wr(5'd24, 16'hABCD);
        check("R3", "status right after halt write", int'(status), 0);
        feed(2, 22, 1'b1);
        check("R3", "status at cycle end", int'(status), 8'h80);
        check_sums("R3");
    endtask

    task automatic t_stopped();
        feed(3, 31, 1'b0);
        check_sums("R4");
        check("R4", "status while stopped", int'(status), 8'h80);
        wr(5'd24, 16'h0001);
        check("R7", "status after idle halt", int'(status), 8'h80);
        step(1'b1, 50, -60, 1'b1, 5'd25, 16'h5A5A);
        check("R6", "status after restart", int'(status), 0);
        clr_exp();
        feed(4, 32, 1'b1);
        check_sums("R6");
        check("R7", "no stale halt", int'(status), 0);
        clr_exp();
        feed(4, 33, 1'b1);
        check("R7", "still running", int'(status), 0);
        check_sums("R2");
    endtask

    task automatic t_restart_run();
        clr_exp();
        feed(2, 41, 1'b1);
        wr(5'd25, 16'h0000);
        feed(2, 42, 1'b1);
        check_sums("R8");
        check("R8", "status", int'(status), 0);
    endtask

    task automatic t_host();
        wr(5'd21, 16'h0001);
        clr_exp();
        feed(4, 51, 1'b1);
        check("R5", "auto stop", int'(status), 8'h80);
        check_sums("R5");
        feed(2, 52, 1'b0);
        check_sums("R4");
        wr(5'd25, 16'h0000);
        clr_exp();
        feed(4, 53, 1'b1);
        check("R5", "auto stop again", int'(status), 8'h80);
        check_sums("R5");
        wr(5'd21, 16'h0000);
        wr(5'd25, 16'h0000);
        clr_exp();
        feed(4, 54, 1'b1);
        check("R2", "free-run after host mode", int'(status), 0);
        check_sums("R2");
    endtask

    task automatic t_len_zero();
        wr(5'd20, 16'd0);
        clr_exp();
        feed(1, 61, 1'b1);
        check_sums("R9");
        clr_exp();
        feed(1, 62, 1'b1);
        check_sums("R9");
        check("R9", "status", int'(status), 0);
    endtask

    initial begin
        #(CLK_T * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        samp_valid = 1'b0;
        samp_i     = '0;
        samp_q     = '0;
        reg_wr     = 1'b0;
        reg_addr   = '0;
        reg_wdata  = '0;
        #(CLK_T / 4);
        t_reset();
        t_default_len();
        t_free_run();
        t_halt();
        t_stopped();
        t_restart_run();
        t_host();
        t_len_zero();
        t_reset();
        t_default_len();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule